// File: doc/BRIEF.md
# Wake-Event Control Register

This block is the control and status word behind the wake-up logic of a network controller. It holds the wake-mode enables, three sticky event flags (link change, pattern match, magic packet), an override that forces the power-management request pin, and a polarity select for the PHY reset pin. It watches three single-cycle event pulses from neighbouring engines and turns the latched flags into the power-management request output.

Software reaches the word through a plain register port. A write lands on the clock edge where `bus_wr` is high. A read issued with `bus_rd` returns its data one cycle later, flagged by `bus_rvalid`. The mode and polarity bits accept writes only while the controller is stopped or suspended. The flags and the broadcast-accept bit accept writes at any time. Three reset inputs model the power-on, hardware and software reset domains. Each domain clears a different set of bits.

The bus port is a control path. It has no back-pressure: every write and every read request is accepted in the cycle it is presented.

Top module: `wake_ctl_reg`

## Requirements
- R1: Bits 31:16 and bits 3:1 of the word ignore writes and always read as 0.
- R2: `pme_req` is 1 in either of two cases. The first is `pme_en`=1 with any flag (bit 9, bit 7 or bit 5) set. The second is the override bit (bit 10) set with bit 9 or bit 5 set, whatever `pme_en` is. In every other case `pme_req` is 0. The pattern flag alone never triggers the override.
- R3: A `ev_link_chg` pulse sets the link flag (bit 9) at the next clock edge only when the link wake mode (bit 8) is 1.
- R4: A `ev_pat_match` pulse sets the pattern flag (bit 7) only when `pat_mode_en` is 1. Bus writes never change bit 7.
- R5: A `ev_magic` pulse sets the magic flag (bit 5) only while magic mode is active. Magic mode is active when the pin-enable bit (bit 4) is 1 or `magic_mode_in` is 1.
- R6: A write stores the written value of bits 9, 6 and 5 at any time, so writing 0 clears a flag. If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R7: A write stores the written value of bits 10, 8, 4 and 0 only when `stop` or `spnd` is 1. In every other cycle a write leaves those bits unchanged, and deasserting `stop` does not change them either.
- R8: `hw_rst` clears bits 10, 8, 6, 4 and 0 and leaves the flags untouched. `sw_rst` clears only bit 6.
- R9: `por_n` low clears the whole word, including the flags, which no other reset touches.
- R10: When bit 0 is 1, `phy_rst_pin` is the inverse of `phy_rst_req` (active low). When bit 0 is 0, `phy_rst_pin` equals `phy_rst_req`.
- R11: A read request in cycle n gives `bus_rvalid`=1 in cycle n+1, with `bus_rdata` holding the word as it stood before edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| stop | input | 1 | Controller stopped |
| spnd | input | 1 | Controller suspended |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| ev_link_chg | input | 1 | Link status change pulse |
| ev_pat_match | input | 1 | Pattern match pulse |
| pat_mode_en | input | 1 | Pattern-match wake mode enable |
| ev_magic | input | 1 | Magic packet detected pulse |
| magic_mode_in | input | 1 | External magic mode request |
| pme_en | input | 1 | Normal power-management request enable |
| pme_req | output | 1 | Power-management request pin |
| phy_rst_req | input | 1 | Internal PHY reset request, active high |
| phy_rst_pin | output | 1 | PHY reset pin, polarity set by bit 0 |

## Verification
Every state bit changes on the clock edge where its write, event or synchronous reset is presented. `pme_req` and `phy_rst_pin` are combinational from that state, so they are due in the same cycle just after that edge. Read data comes one edge after the request.

The bench drives inputs on the falling edge and holds each strobe for exactly one rising edge. It checks the pins at the next falling edge. For a read, it raises `bus_rd` for one rising edge and samples `bus_rdata` and `bus_rvalid` at the following falling edge.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W  = 32;
  localparam int LIVE_W = 16;
  localparam int NFLAG  = 3;

  localparam int B_OVR     = 10;
  localparam int B_LC_FLAG = 9;
  localparam int B_LC_MODE = 8;
  localparam int B_PM_FLAG = 7;
  localparam int B_BCAST   = 6;
  localparam int B_MP_FLAG = 5;
  localparam int B_MP_PIN  = 4;
  localparam int B_POL     = 0;

  // flag vector order
  localparam int F_MP = 0;
  localparam int F_PM = 1;
  localparam int F_LC = 2;

  localparam logic [LIVE_W-1:0] GATED_MASK =
    LIVE_W'((1 << B_OVR) | (1 << B_LC_MODE) | (1 << B_MP_PIN) | (1 << B_POL));
  localparam logic [LIVE_W-1:0] PLAIN_MASK = LIVE_W'(1 << B_BCAST);
  localparam logic [LIVE_W-1:0] SWCLR_MASK = LIVE_W'(1 << B_BCAST);
  localparam logic [NFLAG-1:0]  FLAG_WR_MASK = NFLAG'((1 << F_MP) | (1 << F_LC));
endpackage

// File: rtl/wake_cfg_bank.sv
module wake_cfg_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] GATED = '0,
  parameter logic [W-1:0] PLAIN = '0,
  parameter logic [W-1:0] SWCLR = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         hw_rst,
  input  logic         sw_rst,
  input  logic         gate_open,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q
);
  localparam logic [W-1:0] LIVE = GATED | PLAIN;

  logic unused_wd;
  assign unused_wd = ^(wdata & ~LIVE);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic wr_ok;
      logic clr;
      assign wr_ok = wr && (!GATED[i] || gate_open);
      assign clr   = hw_rst || (SWCLR[i] && sw_rst);
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      cfg_q[i] <= 1'b0;
        else if (clr)    cfg_q[i] <= 1'b0;
        else if (wr_ok)  cfg_q[i] <= wdata[i];
      end
    end else begin : g_tie
      assign cfg_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/wake_flag_bank.sv
module wake_flag_bank #(
  parameter int N = 3,
  parameter logic [N-1:0] WR_MASK = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] set,
  input  logic         wr,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] flag_q
);
  logic unused_wv;
  assign unused_wv = ^(wr_val & ~WR_MASK);

  for (genvar i = 0; i < N; i++) begin : g_flag
    if (WR_MASK[i]) begin : g_rw
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     flag_q[i] <= 1'b0;
        else if (set[i]) flag_q[i] <= 1'b1;
        else if (wr)    flag_q[i] <= wr_val[i];
      end
    end else begin : g_ro
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      flag_q[i] <= 1'b0;
        else if (set[i]) flag_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wake_pin_out.sv
module wake_pin_out (
  input  logic pme_en,
  input  logic ovr,
  input  logic lc_flag,
  input  logic pm_flag,
  input  logic mp_flag,
  input  logic pol_low,
  input  logic phy_req,
  output logic pme_req,
  output logic phy_pin
);
  logic any_flag;
  logic ovr_hit;
  assign any_flag = lc_flag | pm_flag | mp_flag;
  assign ovr_hit  = ovr & (lc_flag | mp_flag);
  assign pme_req  = (pme_en & any_flag) | ovr_hit;
  assign phy_pin  = pol_low ? ~phy_req : phy_req;
endmodule

// File: rtl/wake_ctl_reg.sv
module wake_ctl_reg
  import wake_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             hw_rst,
  input  logic             sw_rst,
  input  logic             stop,
  input  logic             spnd,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             bus_rd,
  output logic [REG_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic             ev_link_chg,
  input  logic             ev_pat_match,
  input  logic             pat_mode_en,
  input  logic             ev_magic,
  input  logic             magic_mode_in,
  input  logic             pme_en,
  output logic             pme_req,
  input  logic             phy_rst_req,
  output logic             phy_rst_pin
);
  logic [LIVE_W-1:0] cfg_q;
  logic [NFLAG-1:0]  flag_q;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_wv;
  logic [LIVE_W-1:0] flag_word;
  logic [REG_W-1:0]  rd_word;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[REG_W-1:LIVE_W];

  wake_cfg_bank #(
    .W(LIVE_W), .GATED(GATED_MASK), .PLAIN(PLAIN_MASK), .SWCLR(SWCLR_MASK)
  ) u_cfg (
    .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .sw_rst(sw_rst),
    .gate_open(stop | spnd), .wr(bus_wr), .wdata(bus_wdata[LIVE_W-1:0]),
    .cfg_q(cfg_q)
  );

  assign flag_set[F_LC] = ev_link_chg  & cfg_q[B_LC_MODE];
  assign flag_set[F_PM] = ev_pat_match & pat_mode_en;
  assign flag_set[F_MP] = ev_magic     & (cfg_q[B_MP_PIN] | magic_mode_in);

  assign flag_wv[F_LC] = bus_wdata[B_LC_FLAG];
  assign flag_wv[F_PM] = bus_wdata[B_PM_FLAG];
  assign flag_wv[F_MP] = bus_wdata[B_MP_FLAG];

  wake_flag_bank #(.N(NFLAG), .WR_MASK(FLAG_WR_MASK)) u_flag (
    .clk(clk), .por_n(por_n), .set(flag_set), .wr(bus_wr),
    .wr_val(flag_wv), .flag_q(flag_q)
  );

  always_comb begin
    flag_word = '0;
    flag_word[B_LC_FLAG] = flag_q[F_LC];
    flag_word[B_PM_FLAG] = flag_q[F_PM];
    flag_word[B_MP_FLAG] = flag_q[F_MP];
    rd_word = {{(REG_W-LIVE_W){1'b0}}, cfg_q | flag_word};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  wake_pin_out u_pin (
    .pme_en(pme_en), .ovr(cfg_q[B_OVR]), .lc_flag(flag_q[F_LC]),
    .pm_flag(flag_q[F_PM]), .mp_flag(flag_q[F_MP]), .pol_low(cfg_q[B_POL]),
    .phy_req(phy_rst_req), .pme_req(pme_req), .phy_pin(phy_rst_pin)
  );
endmodule

// File: rtl/wake_ctl_reg_chk.sv
module wake_ctl_reg_chk (
  input logic        clk,
  input logic        por_n,
  input logic        hw_rst,
  input logic        sw_rst,
  input logic        stop,
  input logic        spnd,
  input logic        bus_rd,
  input logic        bus_rvalid,
  input logic [31:0] bus_rdata,
  input logic        ev_link_chg,
  input logic        pme_req,
  input logic        phy_rst_req,
  input logic        phy_rst_pin,
  input logic [15:0] cfg_q,
  input logic [2:0]  flag_q
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
    bus_rvalid |-> (bus_rdata[31:16] == 16'h0 && bus_rdata[3:1] == 3'b0));

  p_ovr_force_r2: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_q[10] && (flag_q[2] || flag_q[0])) |-> pme_req);

  p_link_set_r3: assert property (@(posedge clk) disable iff (!por_n)
    (ev_link_chg && cfg_q[8]) |=> flag_q[2]);

  p_gated_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!stop && !spnd && !hw_rst) |=> ((cfg_q & 16'h0511) == ($past(cfg_q) & 16'h0511)));

  p_hw_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
    hw_rst |=> ((cfg_q & 16'h0551) == 16'h0));

  p_sw_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> !cfg_q[6]);

  p_pol_low_r10: assert property (@(posedge clk) disable iff (!por_n)
    cfg_q[0] |-> (phy_rst_pin != phy_rst_req));

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd |=> bus_rvalid);
endmodule

bind wake_ctl_reg wake_ctl_reg_chk u_chk (
  .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .sw_rst(sw_rst),
  .stop(stop), .spnd(spnd), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .ev_link_chg(ev_link_chg), .pme_req(pme_req),
  .phy_rst_req(phy_rst_req), .phy_rst_pin(phy_rst_pin),
  .cfg_q(cfg_q), .flag_q(flag_q)
);

// File: tb/sim_wake_ctl_reg.sv
module sim_wake_ctl_reg;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        por_n, hw_rst, sw_rst, stop, spnd, bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, ev_link_chg, ev_pat_match, pat_mode_en;
  logic        ev_magic, magic_mode_in, pme_en, pme_req, phy_rst_req, phy_rst_pin;

  wake_ctl_reg u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        stp;
    logic        spd;
    logic [31:0] wd;
    logic [15:0] exp;
  } vec_t;

  // R7/R6/R1 write-gating walk; expected word after each write
  localparam vec_t VEC [7] = '{
    '{1'b0, 1'b0, 32'hFFFF_FFFF, 16'h0260},
    '{1'b0, 1'b0, 32'h0000_0000, 16'h0000},
    '{1'b1, 1'b0, 32'hFFFF_FFFF, 16'h0771},
    '{1'b0, 1'b0, 32'h0000_0000, 16'h0511},
    '{1'b0, 1'b1, 32'h0000_0100, 16'h0100},
    '{1'b1, 1'b0, 32'h0000_0011, 16'h0011},
    '{1'b0, 1'b0, 32'h0000_0040, 16'h0051}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic s, input logic [31:0] d);
    @(negedge clk);
    stop = s; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; stop = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " rvalid"}, {31'b0, bus_rvalid}, 32'd1);
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse_link();
    @(negedge clk); ev_link_chg = 1'b1;
    @(negedge clk); ev_link_chg = 1'b0;
  endtask
  task automatic pulse_pat();
    @(negedge clk); ev_pat_match = 1'b1;
    @(negedge clk); ev_pat_match = 1'b0;
  endtask
  task automatic pulse_magic();
    @(negedge clk); ev_magic = 1'b1;
    @(negedge clk); ev_magic = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; hw_rst = 0; sw_rst = 0; stop = 0; spnd = 0;
    bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ev_link_chg = 0; ev_pat_match = 0; pat_mode_en = 0;
    ev_magic = 0; magic_mode_in = 0; pme_en = 0; phy_rst_req = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 reset pme", {31'b0, pme_req}, 32'd0);
    check("R9 reset rvalid", {31'b0, bus_rvalid}, 32'd0);
    rd_chk("R9 reset word", 32'h0);

    // vector table walk
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      spnd = VEC[i].spd;
      wr_word(VEC[i].stp, VEC[i].wd);
      spnd = 1'b0;
      rd_chk($sformatf("R7 vec%0d", i), {16'h0, VEC[i].exp});
    end

    // R10 polarity (bit0 = 1 now)
    phy_rst_req = 1'b0; @(negedge clk);
    check("R10 low pol idle", {31'b0, phy_rst_pin}, 32'd1);
    phy_rst_req = 1'b1; @(negedge clk);
    check("R10 low pol active", {31'b0, phy_rst_pin}, 32'd0);
    wr_word(1'b1, 32'h0);
    check("R10 high pol active", {31'b0, phy_rst_pin}, 32'd1);
    phy_rst_req = 1'b0; @(negedge clk);
    check("R10 high pol idle", {31'b0, phy_rst_pin}, 32'd0);

    // R4 pattern flag
    pulse_pat();
    rd_chk("R4 mode off", 32'h0);
    pat_mode_en = 1'b1;
    pulse_pat();
    pat_mode_en = 1'b0;
    rd_chk("R4 set", 32'h0080);
    wr_word(1'b1, 32'h0);
    rd_chk("R4 read-only", 32'h0080);

    // R3 link flag
    pulse_link();
    rd_chk("R3 mode off", 32'h0080);
    wr_word(1'b1, 32'h0100);
    pulse_link();
    rd_chk("R3 set", 32'h0380);

    // R6 event beats clearing write
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 32'h0; ev_link_chg = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_link_chg = 1'b0;
    rd_chk("R6 event wins", 32'h0380);
    wr_word(1'b0, 32'h0);
    rd_chk("R6 write clears", 32'h0180);

    // R5 magic flag
    pulse_magic();
    rd_chk("R5 mode off", 32'h0180);
    magic_mode_in = 1'b1;
    pulse_magic();
    magic_mode_in = 1'b0;
    rd_chk("R5 ext mode", 32'h01A0);
    wr_word(1'b0, 32'h0);
    rd_chk("R5 cleared", 32'h0180);
    wr_word(1'b1, 32'h0110);
    pulse_magic();
    rd_chk("R5 pin mode", 32'h01B0);

    // R2 pme
    check("R2 no enable", {31'b0, pme_req}, 32'd0);
    wr_word(1'b1, 32'h0530);
    check("R2 override magic", {31'b0, pme_req}, 32'd1);
    wr_word(1'b0, 32'h0);
    rd_chk("R2 state", 32'h0590);
    check("R2 override ignores pattern", {31'b0, pme_req}, 32'd0);
    pme_en = 1'b1; @(negedge clk);
    check("R2 enable pattern", {31'b0, pme_req}, 32'd1);
    pme_en = 1'b0;

    // R8 resets
    wr_word(1'b0, 32'h0040);
    rd_chk("R8 bcast set", 32'h05D0);
    @(negedge clk); sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    rd_chk("R8 sw reset", 32'h0590);
    wr_word(1'b1, 32'h05D1);
    rd_chk("R8 pre hw", 32'h05D1);
    @(negedge clk); hw_rst = 1'b1; @(negedge clk); hw_rst = 1'b0;
    rd_chk("R8 hw reset", 32'h0080);

    // R9 power-on clears flags
    wr_word(1'b0, 32'h0220);
    rd_chk("R9 pre por", 32'h02A0);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    rd_chk("R9 por clear", 32'h0);

    // R1 reserved bits with stop
    wr_word(1'b1, 32'hFFFF_000E);
    rd_chk("R1 reserved", 32'h0);

    // R11 latency: no read -> no valid
    @(negedge clk);
    check("R11 idle rvalid", {31'b0, bus_rvalid}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule